// File: doc/BRIEF.md
# Time-Sliced Single-Port RAM with a Write Port and a Read Port

This block gives a system one write port and one read port that both work in every system cycle, while it keeps a single single-port storage array. The array runs on a clock at twice the system rate. Each system cycle is split into two fast cycles. The first fast cycle is the write slot and the second is the read slot. A phase input marks which slot the current fast cycle is. The wrapper samples both port requests at the system edge and holds them for both slots. It steers the one array address between the two requests and registers the read result so that it lines up with the system clock.

The phase input is high during the read slot. The fast clock edge that ends a read slot is the system clock edge. When both ports name the same address in one system cycle, the read returns the word as it was before that cycle's write. The array's access in the write slot already returns that old word, so the wrapper keeps it and hands it to the read port in place of the freshly written value.

Top module: `tdm_sp_ram`

## Requirements
- R1: While reset is active, and at the first system edge after it, `rd_data` is all zeros, and no request captured before reset is carried out.
- R2: A write sampled at a system edge with `wr_en` high stores `wr_data` at `wr_addr`. A read of that address sampled at any later system edge returns that word.
- R3: A read sampled at system edge k (`rd_en` high) presents the stored word at `rd_addr` on `rd_data` from system edge k+1 onward. `rd_data` changes only at an edge that closes a read slot in which a read was pending.
- R4: When a write and a read are sampled at the same system edge with equal addresses, the read returns the word held before that write (read-before-write). The write still takes effect for later reads.
- R5: A system cycle sampled with `rd_en` low leaves `rd_data` unchanged at the following system edge.
- R6: A system cycle sampled with `wr_en` low changes no stored word, whatever `wr_addr` and `wr_data` carry.
- R7: The array is written only in the write slot (`phase_rd` low), and the read slot uses the read address. A write and a read to different addresses in the same system cycle both complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at twice the system rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_rd | input | 1 | High during the read slot. The edge that ends it is the system edge |
| wr_en | input | 1 | Write request, sampled at the system edge |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request, sampled at the system edge |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read result, one system cycle after the request |

## Verification
The bench aims at same-address collisions, both alone and back to back on one address. A wrapper that let the write slot commit before serving the read would return the new word there instead of the old one. It also runs cycles where the disabled port carries live-looking address and data, which catches a design that writes without `wr_en` or refreshes `rd_data` without `rd_en`. A constrained random stream on a 16-word space forces frequent collisions and mixed write/read pairs. A mid-run reset checks that a request captured just before reset leaves no trace.

// File: rtl/tdm_sp_ram.sv
module tdm_sp_ram #(
  parameter int AW = 4,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_rd,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic          we_q, re_q;
  logic [AW-1:0] wa_q, ra_q;
  logic [DW-1:0] wd_q, old_q, rd_q;
  logic [DW-1:0] mem [DEPTH];

  // one address per fast cycle: write slot first, read slot second
  wire          arr_we   = we_q && !phase_rd;
  wire [AW-1:0] arr_addr = phase_rd ? ra_q : wa_q;
  wire [DW-1:0] arr_dout = mem[arr_addr];
  wire          coll     = we_q && re_q && (wa_q == ra_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      wa_q <= '0;
      ra_q <= '0;
      wd_q <= '0;
    end else if (phase_rd) begin
      we_q <= wr_en;
      re_q <= rd_en;
      wa_q <= wr_addr;
      ra_q <= rd_addr;
      wd_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (arr_we) mem[arr_addr] <= wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 old_q <= '0;
    else if (arr_we)            old_q <= arr_dout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rd_q <= '0;
    else if (phase_rd && re_q)  rd_q <= coll ? old_q : arr_dout;
  end

  assign rd_data = rd_q;

endmodule

module tdm_sp_ram_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          phase_rd,
  input logic          we_q,
  input logic          re_q,
  input logic          arr_we,
  input logic          coll,
  input logic [DW-1:0] old_q,
  input logic [DW-1:0] rd_data
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> rd_data == '0);

  p_change_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(phase_rd && re_q));

  p_old_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_rd && coll) |=> rd_data == $past(old_q));

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_rd && !re_q) |=> $stable(rd_data));

  p_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_q |-> !arr_we);

  p_write_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !phase_rd);

endmodule

bind tdm_sp_ram tdm_sp_ram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_rd(phase_rd), .we_q(we_q), .re_q(re_q),
  .arr_we(arr_we), .coll(coll), .old_q(old_q), .rd_data(rd_data)
);

// File: tb/sim_tdm_sp_ram.sv
module sim_tdm_sp_ram;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, phase_rd = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_a = '0, exp_b = '0;
  string tag_a = "R1", tag_b = "R1";

  always #2 clk = ~clk;
  always @(posedge clk) phase_rd <= ~phase_rd;

  tdm_sp_ram #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .phase_rd(phase_rd), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data));

  // {we, waddr, wdata, re, raddr}
  localparam logic [17:0] VEC [14] = '{
    {1'b1, 4'd5,  8'hA1, 1'b1, 4'd5},
    {1'b1, 4'd5,  8'hB2, 1'b1, 4'd5},
    {1'b0, 4'd5,  8'hFF, 1'b1, 4'd5},
    {1'b1, 4'd2,  8'h3C, 1'b1, 4'd9},
    {1'b0, 4'd9,  8'h00, 1'b0, 4'd2},
    {1'b1, 4'd0,  8'h11, 1'b1, 4'd15},
    {1'b1, 4'd15, 8'h22, 1'b1, 4'd0},
    {1'b0, 4'd7,  8'hEE, 1'b1, 4'd15},
    {1'b1, 4'd7,  8'h5A, 1'b0, 4'd7},
    {1'b0, 4'd7,  8'h00, 1'b1, 4'd7},
    {1'b1, 4'd3,  8'h99, 1'b1, 4'd3},
    {1'b1, 4'd3,  8'h98, 1'b1, 4'd3},
    {1'b1, 4'd3,  8'h97, 1'b1, 4'd3},
    {1'b0, 4'd0,  8'h00, 1'b1, 4'd3}
  };

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic we, input logic [AW-1:0] wa,
                                   input logic re, input logic [AW-1:0] ra);
    if (!re) return "R5";
    if (we && wa == ra) return "R4";
    if (we) return "R7";
    return "R3";
  endfunction

  task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input logic re, input logic [AW-1:0] ra, input string tag);
    @(negedge clk);
    while (!phase_rd) @(negedge clk);
    check(rd_data, exp_b, tag_b);
    exp_b = exp_a;
    tag_b = tag_a;
    if (re) exp_a = model[ra];
    tag_a = tag;
    if (we) model[wa] = wd;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    check(rd_data, '0, "R1");
    rst_n = 1'b1;
    for (int a = 0; a < DEPTH; a++)
      step(1'b1, AW'(a), DW'(a * 29 + 7), 1'b0, '0, "R5");
    for (int a = 0; a < DEPTH; a++)
      step(1'b0, '0, '0, 1'b1, AW'(a), "R2");
    for (int i = 0; i < 14; i++) begin
      logic [17:0] v;
      v = VEC[i];
      step(v[17], v[16:13], v[12:5], v[4], v[3:0], tag_of(v[17], v[16:13], v[4], v[3:0]));
    end
    // disabled write with live-looking fields, then read back
    step(1'b0, 4'd6, 8'h00, 1'b0, 4'd6, "R5");
    step(1'b0, 4'd6, 8'hC3, 1'b1, 4'd6, "R6");
    step(1'b0, 4'd6, 8'h7E, 1'b0, 4'd1, "R5");
    step(1'b0, 4'd6, 8'h7E, 1'b0, 4'd1, "R5");
    for (int i = 0; i < 400; i++) begin
      logic we, re;
      logic [AW-1:0] wa, ra;
      logic [DW-1:0] wd;
      we = 1'($urandom); re = 1'($urandom % 4 != 0);
      wa = AW'($urandom); ra = ($urandom % 3 == 0) ? wa : AW'($urandom);
      wd = DW'($urandom);
      step(we, wa, wd, re, ra, tag_of(we, wa, re, ra));
    end
    // mid-run reset: a write captured just before reset must be dropped
    step(1'b0, '0, '0, 1'b0, '0, "R5");
    step(1'b0, '0, '0, 1'b0, '0, "R5");
    @(negedge clk);
    while (!phase_rd) @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'h42; rd_en = 1'b1; rd_addr = 4'd8;
    @(posedge clk);
    #1 rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_data, '0, "R1");
    rst_n = 1'b1;
    exp_a = '0; exp_b = '0; tag_a = "R1"; tag_b = "R1";
    step(1'b0, '0, '0, 1'b1, 4'd8, "R1");
    step(1'b0, '0, '0, 1'b0, '0, "R5");
    step(1'b0, '0, '0, 1'b0, '0, "R5");
    step(1'b0, '0, '0, 1'b0, '0, "R5");
  endtask

  initial begin
    fork
      run();
      begin
        #400000;
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule